// File: doc/BRIEF.md
# PLL Mode Control Sequencer

This block is the digital control for a clock synthesizer. It takes the operating mode from a 3-bit configuration field written over a plain write strobe. It mirrors the accepted field into three status bits and rejects codes that name no valid mode. From that field, and from two plain inputs, it steps the synthesizer through four states: off, self-clocked, waiting for lock and locked. The two inputs are a reference-clock-valid flag from a clock monitor and a lock flag from the analog loop.

The block holds the oscillator in reset while power-on reset is high and while the PLL is not configured. The system clock source select starts on the internal RC oscillator. It moves to the PLL output only when the loop is locked and software asks for the PLL. It falls back to the RC oscillator on the edge where lock is lost. The multiplier divider keeps its default value until the loop has locked once. Divider writes before that point are dropped.

Top module: `pll_mode_seq`

## Requirements
- R1: After a cycle with `rst` or `por` high, the configuration field and the status bits are 000, `lock_state` is 0 (off), `sys_clk_pll` is 0 (internal RC oscillator), `cfg_err` is 0 and `div_value` equals `DIV_DEF`.
- R2: `osc_rst` is 1 on the cycle after any cycle in which `por` is high. After a write, `osc_rst` equals the inverse of the accepted field's bit 2, updated on the same edge as the status bits.
- R3: A write whose bit 2 is 0 (codes 0xx, PLL off) is accepted. The status bits {`stat_mode`,`stat_sel`,`stat_ref`} show the written code one cycle later, and `lock_state` is 0 (off) one cycle after that.
- R4: Writes of 110 (normal mode, external reference) and 111 (normal mode, crystal reference) are accepted. The status bits show the code one cycle later and `cfg_err` clears on the same edge.
- R5: Writes of 100 and 101 are reserved and ignored. The status bits keep their previous value and `cfg_err` becomes 1 on the next cycle. It stays 1 until the next accepted write.
- R6: With bit 2 of the status set and `por` low, the state leaves off for self-clocked (`lock_state` = 1). It stays self-clocked for as long as `ref_valid` is 0.
- R7: From self-clocked, `ref_valid` = 1 moves the state to waiting for lock (2), and `pll_lock` = 1 then moves it to locked (3). Loss of `ref_valid` in state 2 or 3 returns it to self-clocked (1) on the next edge.
- R8: `sys_clk_pll` is 1 only while `lock_state` is 3 and `src_req` was 1 at the preceding edge. It changes on the same edge as `lock_state`.
- R9: When `pll_lock` falls in the locked state, the next edge sets `lock_state` to 2 and `sys_clk_pll` to 0.
- R10: A divider write before the first lock since reset leaves `div_value` unchanged. From the edge that first enters the locked state onward, a write updates `div_value` one cycle later, even if lock is later lost. A reset clears this permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por | input | 1 | Power-on reset, synchronous active-high |
| cfg_wr | input | 1 | Write strobe for the configuration field |
| cfg_data | input | 3 | Configuration code |
| div_wr | input | 1 | Write strobe for the divider |
| div_data | input | DIV_W | New divider value |
| ref_valid | input | 1 | Reference clock valid from the clock monitor |
| pll_lock | input | 1 | Loop lock indication |
| src_req | input | 1 | Software request to run the system from the PLL |
| stat_mode | output | 1 | Status: PLL mode (field bit 2) |
| stat_sel | output | 1 | Status: normal-mode select (field bit 1) |
| stat_ref | output | 1 | Status: reference type, 1 = crystal (field bit 0) |
| cfg_err | output | 1 | Last configuration write was reserved |
| osc_rst | output | 1 | Oscillator held in reset |
| lock_state | output | 2 | 0 off, 1 self-clocked, 2 waiting for lock, 3 locked |
| sys_clk_pll | output | 1 | System clock source: 1 PLL, 0 internal RC oscillator |
| div_value | output | DIV_W | Current multiplier divider value |

## Verification
The checker tests these rules on every cycle:
- a reserved write leaves the status bits unchanged and raises the error flag;
- power-on reset forces the oscillator reset;
- an off field drives the state to off;
- the self-clocked state holds while the reference is invalid;
- the PLL source is only selected in the locked state, and is dropped on lock loss;
- pre-lock divider writes have no effect.

Some behaviour only the bench scenarios show. One case is the full walk through every code with the status and error flag it leaves behind. Others are the order of state steps from off to locked and back through both loss paths. The bench also shows that the divider permission survives lock loss but is cleared by reset.

// File: rtl/pll_mode_pkg.sv
package pll_mode_pkg;
  localparam int CFG_W = 3;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_SCM  = 2'd1,
    ST_WAIT = 2'd2,
    ST_LOCK = 2'd3
  } lock_st_t;

  // mode bit set but normal-select clear names no valid mode
  function automatic logic cfg_reserved(input logic [CFG_W-1:0] code);
    return code[2] & ~code[1];
  endfunction
endpackage

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_all,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_data,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CFG_W-1:0] cfg_nxt,
  output logic             err_q
);
  logic bad_code;

  assign bad_code = cfg_reserved(cfg_data);

  always_comb begin
    cfg_nxt = cfg_q;
    if (cfg_wr && !bad_code) cfg_nxt = cfg_data;
  end

  always_ff @(posedge clk) begin
    if (rst_all) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      cfg_q <= cfg_nxt;
      if (cfg_wr) err_q <= bad_code;
    end
  end
endmodule

// File: rtl/pll_mode_fsm.sv
module pll_mode_fsm
  import pll_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_all,
  input  logic       mode_q,
  input  logic       mode_nxt,
  input  logic       ref_valid,
  input  logic       pll_lock,
  input  logic       src_req,
  output logic [1:0] state_o,
  output logic       sel_pll_o,
  output logic       osc_rst_o,
  output logic       first_lock_o
);
  lock_st_t st_q, st_nxt;

  always_comb begin
    st_nxt = st_q;
    if (!mode_q) begin
      st_nxt = ST_OFF;
    end else if (!ref_valid) begin
      st_nxt = ST_SCM;
    end else begin
      case (st_q)
        ST_OFF:  st_nxt = ST_SCM;
        ST_SCM:  st_nxt = ST_WAIT;
        ST_WAIT: st_nxt = pll_lock ? ST_LOCK : ST_WAIT;
        ST_LOCK: st_nxt = pll_lock ? ST_LOCK : ST_WAIT;
        default: st_nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst_all) begin
      st_q         <= ST_OFF;
      sel_pll_o    <= 1'b0;
      osc_rst_o    <= 1'b1;
      first_lock_o <= 1'b0;
    end else begin
      st_q         <= st_nxt;
      sel_pll_o    <= (st_nxt == ST_LOCK) && src_req;
      osc_rst_o    <= !mode_nxt;
      first_lock_o <= first_lock_o | (st_nxt == ST_LOCK);
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/pll_div_gate.sv
module pll_div_gate #(
  parameter int               DIV_W   = 7,
  parameter logic [DIV_W-1:0] DIV_DEF = 7'd32
) (
  input  logic             clk,
  input  logic             rst_all,
  input  logic             first_lock,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_data,
  output logic [DIV_W-1:0] div_q
);
  always_ff @(posedge clk) begin
    if (rst_all)                  div_q <= DIV_DEF;
    else if (div_wr && first_lock) div_q <= div_data;
  end
endmodule

// File: rtl/pll_mode_seq.sv
module pll_mode_seq
  import pll_mode_pkg::*;
#(
  parameter int               DIV_W   = 7,
  parameter logic [DIV_W-1:0] DIV_DEF = 7'd32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_data,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_data,
  input  logic             ref_valid,
  input  logic             pll_lock,
  input  logic             src_req,
  output logic             stat_mode,
  output logic             stat_sel,
  output logic             stat_ref,
  output logic             cfg_err,
  output logic             osc_rst,
  output logic [1:0]       lock_state,
  output logic             sys_clk_pll,
  output logic [DIV_W-1:0] div_value
);
  logic             rst_all;
  logic [CFG_W-1:0] cfg_q, cfg_nxt;
  logic             first_lock;

  assign rst_all = rst | por;

  pll_cfg_regs u_cfg (
    .clk      (clk),
    .rst_all  (rst_all),
    .cfg_wr   (cfg_wr),
    .cfg_data (cfg_data),
    .cfg_q    (cfg_q),
    .cfg_nxt  (cfg_nxt),
    .err_q    (cfg_err)
  );

  pll_mode_fsm u_fsm (
    .clk          (clk),
    .rst_all      (rst_all),
    .mode_q       (cfg_q[2]),
    .mode_nxt     (cfg_nxt[2]),
    .ref_valid    (ref_valid),
    .pll_lock     (pll_lock),
    .src_req      (src_req),
    .state_o      (lock_state),
    .sel_pll_o    (sys_clk_pll),
    .osc_rst_o    (osc_rst),
    .first_lock_o (first_lock)
  );

  pll_div_gate #(.DIV_W(DIV_W), .DIV_DEF(DIV_DEF)) u_div (
    .clk        (clk),
    .rst_all    (rst_all),
    .first_lock (first_lock),
    .div_wr     (div_wr),
    .div_data   (div_data),
    .div_q      (div_value)
  );

  assign {stat_mode, stat_sel, stat_ref} = cfg_q;
endmodule

// File: rtl/pll_mode_seq_chk.sv
module pll_mode_seq_chk #(
  parameter int DIV_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             por,
  input logic             cfg_wr,
  input logic [2:0]       cfg_data,
  input logic             div_wr,
  input logic             ref_valid,
  input logic             pll_lock,
  input logic             stat_mode,
  input logic             stat_sel,
  input logic             stat_ref,
  input logic             cfg_err,
  input logic             osc_rst,
  input logic [1:0]       lock_state,
  input logic             sys_clk_pll,
  input logic [DIV_W-1:0] div_value,
  input logic             first_lock
);
  // R2
  por_holds_osc_chk: assert property (@(posedge clk) por |=> osc_rst);

  // R3
  off_forces_state_chk: assert property (@(posedge clk) disable iff (rst || por)
    !stat_mode |=> (lock_state == 2'd0));

  // R5
  reserved_ignored_chk: assert property (@(posedge clk) disable iff (rst || por)
    (cfg_wr && cfg_data[2:1] == 2'b10) |=> (cfg_err && $stable({stat_mode, stat_sel, stat_ref})));

  // R6
  scm_holds_chk: assert property (@(posedge clk) disable iff (rst || por)
    (lock_state == 2'd1 && !ref_valid && stat_mode) |=> (lock_state == 2'd1));

  // R8
  pll_src_locked_chk: assert property (@(posedge clk) disable iff (rst || por)
    sys_clk_pll |-> (lock_state == 2'd3));

  // R9
  lock_loss_drop_chk: assert property (@(posedge clk) disable iff (rst || por)
    (lock_state == 2'd3 && !pll_lock) |=> !sys_clk_pll);

  // R10
  div_prelock_chk: assert property (@(posedge clk) disable iff (rst || por)
    (div_wr && !first_lock) |=> $stable(div_value));
endmodule

bind pll_mode_seq pll_mode_seq_chk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/pll_mode_seq_bench.sv
`timescale 1ns/1ps
module pll_mode_seq_bench;
  localparam int          DIV_W   = 7;
  localparam logic [6:0]  DIV_DEF = 7'd32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, por, cfg_wr, div_wr, ref_valid, pll_lock, src_req;
  logic [2:0] cfg_data;
  logic [DIV_W-1:0] div_data;
  logic stat_mode, stat_sel, stat_ref, cfg_err, osc_rst, sys_clk_pll;
  logic [1:0] lock_state;
  logic [DIV_W-1:0] div_value;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  pll_mode_seq #(.DIV_W(DIV_W), .DIV_DEF(DIV_DEF)) u_pll_mode_seq (
    .clk(clk), .rst(rst), .por(por), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .div_wr(div_wr), .div_data(div_data), .ref_valid(ref_valid),
    .pll_lock(pll_lock), .src_req(src_req), .stat_mode(stat_mode),
    .stat_sel(stat_sel), .stat_ref(stat_ref), .cfg_err(cfg_err),
    .osc_rst(osc_rst), .lock_state(lock_state), .sys_clk_pll(sys_clk_pll),
    .div_value(div_value)
  );

  // {write code, expected status, expected cfg_err, expected osc_rst}
  localparam logic [7:0] VEC [8] = '{
    8'b011_011_0_1, 8'b100_011_1_1, 8'b110_110_0_0, 8'b101_110_1_0,
    8'b111_111_0_0, 8'b000_000_0_1, 8'b100_000_1_1, 8'b001_001_0_1
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; por = 1; cfg_wr = 0; cfg_data = 0; div_wr = 0; div_data = 0;
    ref_valid = 0; pll_lock = 0; src_req = 0;
    tick();
    check("R2 osc_rst during por", osc_rst, 1);
    por = 0;
    tick();
    rst = 0;
    // R1 reset state
    check("R1 status", {stat_mode, stat_sel, stat_ref}, 0);
    check("R1 lock_state", lock_state, 0);
    check("R1 sys_clk_pll", sys_clk_pll, 0);
    check("R1 cfg_err", cfg_err, 0);
    check("R1 div_value", div_value, DIV_DEF);

    // R3 R4 R5 configuration walk
    for (int i = 0; i < 8; i++) begin
      cfg_wr = 1; cfg_data = VEC[i][7:5];
      tick();
      check("R3/R4/R5 status", {stat_mode, stat_sel, stat_ref}, VEC[i][4:2]);
      check("R5 cfg_err", cfg_err, VEC[i][1]);
      check("R2 osc_rst", osc_rst, VEC[i][0]);
    end
    cfg_wr = 0;
    tick();
    check("R3 off state", lock_state, 0);

    // R6 enter self-clocked
    cfg_wr = 1; cfg_data = 3'b110;
    tick();
    cfg_wr = 0;
    check("R4 status 110", {stat_mode, stat_sel, stat_ref}, 6);
    check("R2 osc_rst released", osc_rst, 0);
    tick();
    check("R6 self-clocked", lock_state, 1);
    div_wr = 1; div_data = 7'd55;
    tick();
    div_wr = 0;
    tick();
    check("R6 stays self-clocked", lock_state, 1);
    check("R10 pre-lock write rejected", div_value, DIV_DEF);

    // R7 progression
    ref_valid = 1;
    tick();
    check("R7 wait for lock", lock_state, 2);
    pll_lock = 1;
    tick();
    check("R7 locked", lock_state, 3);
    check("R8 no request no pll", sys_clk_pll, 0);
    src_req = 1;
    tick();
    check("R8 pll selected", sys_clk_pll, 1);
    div_wr = 1; div_data = 7'd55;
    tick();
    div_wr = 0;
    check("R10 post-lock write", div_value, 55);

    // R9 lock loss
    pll_lock = 0;
    tick();
    check("R9 state", lock_state, 2);
    check("R9 source", sys_clk_pll, 0);
    pll_lock = 1;
    tick();
    check("R7 relock", lock_state, 3);
    check("R8 reselect", sys_clk_pll, 1);

    // R7 reference loss
    ref_valid = 0;
    tick();
    check("R7 ref loss to scm", lock_state, 1);
    check("R8 source on ref loss", sys_clk_pll, 0);
    div_wr = 1; div_data = 7'd23;
    tick();
    div_wr = 0;
    check("R10 permission kept", div_value, 23);

    // R3 back to off
    cfg_wr = 1; cfg_data = 3'b000;
    tick();
    cfg_wr = 0;
    check("R2 osc_rst on off", osc_rst, 1);
    tick();
    check("R3 off", lock_state, 0);

    // R1 R10 reset clears permission
    rst = 1;
    tick();
    rst = 0;
    check("R1 div after reset", div_value, DIV_DEF);
    cfg_wr = 1; cfg_data = 3'b111;
    tick();
    cfg_wr = 0;
    div_wr = 1; div_data = 7'd9;
    tick();
    div_wr = 0;
    tick();
    check("R10 permission cleared", div_value, DIV_DEF);

    // R2 por mid-run
    por = 1; cfg_wr = 1; cfg_data = 3'b110;
    tick();
    cfg_wr = 0;
    check("R2 osc_rst on por", osc_rst, 1);
    check("R1 status on por", {stat_mode, stat_sel, stat_ref}, 0);
    check("R1 state on por", lock_state, 0);
    por = 0;
    tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule